// File: doc/BRIEF.md
# Ring Oscillator Pair-Compare Response Generator

This block derives a single response bit from a challenge by racing two ring oscillators taken from a bank of identically built oscillators. Each oscillator output arrives as an asynchronous pulse train. Every input is brought into the system clock domain, and each of its rising edges is counted. Two saturating counters, one per selected oscillator, run for the same gate window. The response records which of the two was faster.

There are two ways to choose the pair. In adjacent-pair mode the challenge names one pair of neighbouring oscillators. In masking mode the challenge names a group of `GROUP_K` oscillators. The block measures every member of that group, two per window. It then sweeps all pairs in the group and keeps the one whose counts lie furthest apart. The two local indices of that pair are reported as helper data, so that a later enrolment or reconstruction step can select the same pair again.

A run begins with a `start` pulse while the block is idle. `busy` is high while the run is in progress. A one-cycle `done` marks the cycle in which the response, the tie flag and the helper indices become valid. These outputs keep their values until the next run completes.

Top module: `ro_pair_puf`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `done`, `response`, `unstable`, `helper_lo` and `helper_hi` are all 0.
- R2: A `start` pulse sampled while idle makes `busy` go high in the next cycle. `done` is high for exactly one cycle. In the cycle where `done` is high, `busy` is already low.
- R3: A `start` pulse sampled while `busy` is high is ignored. Neither the result nor the completion time of the run in progress changes, and no extra `done` follows.
- R4: With `mode`=0, challenge value p selects oscillator 2p as lane A and oscillator 2p+1 as lane B. Each lane counts the rising edges of its synchronised oscillator. `response` is 1 exactly when the lane A count is greater than the lane B count.
- R5: The gate window lasts `window_len` system clock cycles, captured at `start`. A value of 0 selects `DEFAULT_WIN` (1024). In `mode`=0, `done` rises on the (window+1)-th rising clock edge after the edge that samples `start`.
- R6: If the two compared counts are equal, `response` is 0 and `unstable` is 1. Otherwise `unstable` is 0.
- R7: Each lane counter stops at 2^CNT_W-1 instead of wrapping. With CNT_W=4, two different oscillators that both exceed 15 edges compare as equal.
- R8: With `mode`=1, challenge bit 0 (the low log2(NUM_OSC/GROUP_K) bits) selects group g, which holds oscillators g*GROUP_K to g*GROUP_K+GROUP_K-1. Members are measured two per window. The pair i<j with the largest absolute count difference is kept. On a tie, the pair met first wins, scanning i ascending and then j ascending. `response` is 1 exactly when count(i) > count(j).
- R9: In `mode`=1, `helper_lo` and `helper_hi` report the local indices i and j of the kept pair. In `mode`=0 both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | NUM_OSC (16) | Asynchronous oscillator outputs |
| start | input | 1 | Begin a run (taken only when idle) |
| mode | input | 1 | 0 = adjacent pair, 1 = masking over a group |
| challenge | input | log2(NUM_OSC/2) (3) | Pair index, or group index in its low bits |
| window_len | input | WIN_W (16) | Gate window in clock cycles, 0 = default |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| response | output | 1 | Response bit |
| unstable | output | 1 | The compared counts were equal |
| helper_lo | output | log2(GROUP_K) (3) | Local index of first kept oscillator |
| helper_hi | output | log2(GROUP_K) (3) | Local index of second kept oscillator |

## Verification
A wrong lane select or a wrong window timer appears at `response` on the first `done` of a run whose two oscillators are far apart in frequency. A timer fault also moves `done` away from its expected edge. A fault in the group sweep state, such as a wrong slot, a lost bank entry or a bad tie rule, appears at `helper_lo`/`helper_hi` on the first masking run. A counter that wraps rather than saturates appears as a cleared `unstable` flag on the first run in which both lanes overflow.

// File: rtl/ropuf_pkg.sv
`timescale 1ns/1ps
package ropuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_STORE  = 2'd2,
        ST_SEARCH = 2'd3
    } ro_state_e;

    typedef enum logic {
        MODE_PAIR = 1'b0,
        MODE_MASK = 1'b1
    } ro_mode_e;

    typedef struct packed {
        logic bit_out;
        logic tie;
    } ro_verdict_t;

    function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic ro_verdict_t judge(input logic [31:0] a, input logic [31:0] b);
        ro_verdict_t v;
        v.bit_out = (a > b);
        v.tie     = (a == b);
        return v;
    endfunction

endpackage

// File: rtl/ro_edge_sync.sv
`timescale 1ns/1ps
module ro_edge_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [2:0] sh;

        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[1:0], async_in[b]};
        end

        assign rise[b] = sh[1] & ~sh[2];

        AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
            rise[b] |=> !rise[b]); // R4
    end

endmodule

// File: rtl/ro_sat_counter.sv
`timescale 1ns/1ps
module ro_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)                  value <= '0;
        else if (inc && (value != TOP))  value <= value + W'(1);
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (value == TOP && !clr) |=> (value == TOP)); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (value >= $past(value))); // R7

endmodule

// File: rtl/ro_max_gap_search.sv
`timescale 1ns/1ps
module ro_max_gap_search
    import ropuf_pkg::*;
#(
    parameter int K = 8,
    parameter int W = 16,
    localparam int IW = $clog2(K)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [K-1:0][W-1:0] counts,
    output logic                fin,
    output logic [IW-1:0]       sel_lo,
    output logic [IW-1:0]       sel_hi
);

    logic          run;
    logic [IW-1:0] i_q, j_q;
    logic [W-1:0]  best_gap, gap;
    logic          last;

    always_comb begin
        gap  = W'(abs_gap(32'(counts[i_q]), 32'(counts[j_q])));
        last = (i_q == IW'(K-2)) && (j_q == IW'(K-1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0; fin <= 1'b0;
            i_q <= '0;   j_q <= IW'(1);
            best_gap <= '0;
            sel_lo <= '0; sel_hi <= IW'(1);
        end else begin
            fin <= 1'b0;
            if (go) begin
                run <= 1'b1;
                i_q <= '0;   j_q <= IW'(1);
                best_gap <= '0;
                sel_lo <= '0; sel_hi <= IW'(1);
            end else if (run) begin
                if (gap > best_gap) begin
                    best_gap <= gap;
                    sel_lo   <= i_q;
                    sel_hi   <= j_q;
                end
                if (last) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end else if (j_q == IW'(K-1)) begin
                    i_q <= i_q + IW'(1);
                    j_q <= IW'(int'(i_q) + 2);
                end else begin
                    j_q <= j_q + IW'(1);
                end
            end
        end
    end

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
        sel_lo < sel_hi); // R8
    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (rst)
        run |-> (i_q < j_q)); // R8
    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin); // R8

endmodule

// File: rtl/ro_pair_puf.sv
`timescale 1ns/1ps
module ro_pair_puf
    import ropuf_pkg::*;
#(
    parameter int NUM_OSC     = 16,
    parameter int GROUP_K     = 8,
    parameter int CNT_W       = 16,
    parameter int WIN_W       = 16,
    parameter int DEFAULT_WIN = 1024,
    localparam int CH_W  = $clog2(NUM_OSC / 2),
    localparam int LOC_W = $clog2(GROUP_K)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] osc_in,
    input  logic               start,
    input  logic               mode,
    input  logic [CH_W-1:0]    challenge,
    input  logic [WIN_W-1:0]   window_len,
    output logic               busy,
    output logic               done,
    output logic               response,
    output logic               unstable,
    output logic [LOC_W-1:0]   helper_lo,
    output logic [LOC_W-1:0]   helper_hi
);

    localparam int NGRP   = NUM_OSC / GROUP_K;
    localparam int GRP_W  = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int IDX_W  = $clog2(NUM_OSC);
    localparam int SLOTS  = GROUP_K / 2;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    // synchronised rising-edge pulses
    logic [NUM_OSC-1:0] rise;

    ro_edge_sync #(.N(NUM_OSC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (osc_in),
        .rise     (rise)
    );

    ro_state_e                  state;
    ro_mode_e                   mode_q;
    logic [CH_W-1:0]            chal_q;
    logic [WIN_W-1:0]           win_q, timer;
    logic [SLOT_W-1:0]          slot;
    logic [GROUP_K-1:0][CNT_W-1:0] bank;
    logic                       done_q, resp_q, unst_q;
    logic [LOC_W-1:0]           lo_q, hi_q;

    // lane selection
    logic [IDX_W-1:0] idx_a, idx_b;

    always_comb begin
        if (mode_q == MODE_MASK)
            idx_a = IDX_W'(int'(chal_q[GRP_W-1:0]) * GROUP_K + 2 * int'(slot));
        else
            idx_a = IDX_W'(2 * int'(chal_q));
        idx_b = idx_a + IDX_W'(1);
    end

    logic [1:0]            lane_inc;
    logic                  lane_clr;
    logic [1:0][CNT_W-1:0] lane_cnt;

    assign lane_inc[0] = (state == ST_COUNT) & rise[idx_a];
    assign lane_inc[1] = (state == ST_COUNT) & rise[idx_b];
    assign lane_clr    = (state == ST_IDLE) || (state == ST_STORE);

    for (genvar L = 0; L < 2; L++) begin : g_lane
        ro_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (lane_clr),
            .inc   (lane_inc[L]),
            .value (lane_cnt[L])
        );
    end

    // group sweep
    logic             srch_go, srch_fin;
    logic [LOC_W-1:0] pick_lo, pick_hi;

    ro_max_gap_search #(.K(GROUP_K), .W(CNT_W)) u_search (
        .clk    (clk),
        .rst    (rst),
        .go     (srch_go),
        .counts (bank),
        .fin    (srch_fin),
        .sel_lo (pick_lo),
        .sel_hi (pick_hi)
    );

    ro_verdict_t v_pair, v_mask;

    always_comb begin
        v_pair = judge(32'(lane_cnt[0]), 32'(lane_cnt[1]));
        v_mask = judge(32'(bank[pick_lo]), 32'(bank[pick_hi]));
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            mode_q  <= MODE_PAIR;
            chal_q  <= '0;
            win_q   <= WIN_W'(1);
            timer   <= '0;
            slot    <= '0;
            bank    <= '0;
            srch_go <= 1'b0;
            done_q  <= 1'b0;
            resp_q  <= 1'b0;
            unst_q  <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            srch_go <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= ro_mode_e'(mode);
                        chal_q <= challenge;
                        win_q  <= (window_len == '0) ? WIN_W'(DEFAULT_WIN) : window_len;
                        timer  <= '0;
                        slot   <= '0;
                        state  <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (timer == win_q - WIN_W'(1)) begin
                        timer <= '0;
                        state <= ST_STORE;
                    end else begin
                        timer <= timer + WIN_W'(1);
                    end
                end
                ST_STORE: begin
                    if (mode_q == MODE_PAIR) begin
                        resp_q <= v_pair.bit_out;
                        unst_q <= v_pair.tie;
                        lo_q   <= '0;
                        hi_q   <= '0;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        bank[LOC_W'(2 * int'(slot))]     <= lane_cnt[0];
                        bank[LOC_W'(2 * int'(slot) + 1)] <= lane_cnt[1];
                        if (slot == SLOT_W'(SLOTS - 1)) begin
                            srch_go <= 1'b1;
                            state   <= ST_SEARCH;
                        end else begin
                            slot  <= slot + SLOT_W'(1);
                            state <= ST_COUNT;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (srch_fin) begin
                        resp_q <= v_mask.bit_out;
                        unst_q <= v_mask.tie;
                        lo_q   <= pick_lo;
                        hi_q   <= pick_hi;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign response  = resp_q;
    assign unstable  = unst_q;
    assign helper_lo = lo_q;
    assign helper_hi = hi_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(chal_q) && $stable(mode_q) && $stable(win_q))); // R3
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |-> (timer < win_q)); // R5
    AST_TIE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && unstable) |-> !response); // R6
    AST_PAIR_HELPERS: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == MODE_PAIR) |-> (helper_lo == '0 && helper_hi == '0)); // R9

endmodule

// File: tb/ro_pair_puf_test.sv
`timescale 1ns/1ps
module ro_pair_puf_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] osc;
    logic        start, mode;
    logic [2:0]  challenge;
    logic [15:0] window_len;
    logic        busy, done, response, unstable;
    logic [2:0]  helper_lo, helper_hi;
    logic        s_busy, s_done, s_resp, s_unst;
    logic [2:0]  s_lo, s_hi;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    ro_pair_puf uut (
        .clk(clk), .rst(rst), .osc_in(osc), .start(start), .mode(mode),
        .challenge(challenge), .window_len(window_len), .busy(busy), .done(done),
        .response(response), .unstable(unstable), .helper_lo(helper_lo), .helper_hi(helper_hi)
    );

    ro_pair_puf #(.CNT_W(4)) uut_sat (
        .clk(clk), .rst(rst), .osc_in(osc), .start(start), .mode(mode),
        .challenge(challenge), .window_len(window_len), .busy(s_busy), .done(s_done),
        .response(s_resp), .unstable(s_unst), .helper_lo(s_lo), .helper_hi(s_hi)
    );

    // oscillator periods in ns, 0 = stopped
    function automatic int osc_period(input int k);
        case (k)
            0: return 20;  1: return 34;  2: return 26;  3: return 44;
            4: return 22;  5: return 30;  6: return 38;  7: return 28;
            8: return 40;  9: return 24; 10: return 36; 11: return 21;
            12: return 32; 13: return 46;
            default: return 0;
        endcase
    endfunction

    initial begin
        int tick;
        tick = 0;
        osc = '0;
        forever begin
            #1;
            tick++;
            for (int k = 0; k < 16; k++) begin
                int p;
                p = osc_period(k);
                osc[k] = (p == 0) ? 1'b0 : (((tick + 3 * k) % p) < (p / 2));
            end
        end
    end

    // {mode, challenge[2:0], response, unstable, helper_lo[2:0], helper_hi[2:0]}
    localparam logic [11:0] VECS [10] = '{
        {1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 3'd0},
        {1'b0, 3'd1, 1'b1, 1'b0, 3'd0, 3'd0},
        {1'b0, 3'd2, 1'b1, 1'b0, 3'd0, 3'd0},
        {1'b0, 3'd3, 1'b0, 1'b0, 3'd0, 3'd0},
        {1'b0, 3'd4, 1'b0, 1'b0, 3'd0, 3'd0},
        {1'b0, 3'd5, 1'b0, 1'b0, 3'd0, 3'd0},
        {1'b0, 3'd6, 1'b1, 1'b0, 3'd0, 3'd0},
        {1'b0, 3'd7, 1'b0, 1'b1, 3'd0, 3'd0},
        {1'b1, 3'd0, 1'b1, 1'b0, 3'd0, 3'd3},
        {1'b1, 3'd1, 1'b1, 1'b0, 3'd3, 3'd6}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic m, input logic [2:0] c, input logic [15:0] w);
        @(negedge clk);
        mode = m; challenge = c; window_len = w; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2", "busy after start", int'(busy), 1);
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (lat < 20000) begin
            @(posedge clk);
            lat++;
            #1;
            if (done) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int dones;
        int lat_done;
        int resp_seen;
        rst = 1'b1; start = 1'b0; mode = 1'b0; challenge = '0; window_len = 16'd256;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "response in reset", int'(response), 0);
        check("R1", "unstable in reset", int'(unstable), 0);
        check("R1", "helpers in reset", int'({helper_lo, helper_hi}), 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1", "busy after release", int'(busy), 0);
        check("R1", "done after release", int'(done), 0);

        // vector table: R4 R6 R8 R9
        for (int v = 0; v < 10; v++) begin
            logic [11:0] e;
            e = VECS[v];
            launch(e[11], e[10:8], 16'd256);
            wait_done(lat);
            check(e[11] ? "R8" : "R4", $sformatf("response vec %0d", v), int'(response), int'(e[7]));
            check("R6", $sformatf("unstable vec %0d", v), int'(unstable), int'(e[6]));
            check("R9", $sformatf("helper_lo vec %0d", v), int'(helper_lo), int'(e[5:3]));
            check("R9", $sformatf("helper_hi vec %0d", v), int'(helper_hi), int'(e[2:0]));
            check("R2", $sformatf("busy low at done vec %0d", v), int'(busy), 0);
            if (v == 0) begin
                check("R5", "pair latency window 256", lat, 257);
                // R7: both lanes saturate at 15 in the narrow instance
                check("R7", "sat instance done", int'(s_done), 1);
                check("R7", "sat instance response", int'(s_resp), 0);
                check("R7", "sat instance unstable", int'(s_unst), 1);
            end
            @(posedge clk); #1;
            check("R2", $sformatf("done one cycle vec %0d", v), int'(done), 0);
        end

        // R5: short window and default window
        launch(1'b0, 3'd0, 16'd16);
        wait_done(lat);
        check("R5", "pair latency window 16", lat, 17);
        launch(1'b0, 3'd3, 16'd0);
        wait_done(lat);
        check("R5", "pair latency default window", lat, 1025);
        check("R4", "pair 3 with default window", int'(response), 0);

        // R3: start while busy is ignored
        launch(1'b0, 3'd0, 16'd256);
        lat = 0; dones = 0; lat_done = 0; resp_seen = 0;
        while (lat < 400) begin
            @(posedge clk);
            lat++;
            #1;
            if (lat == 5) begin start = 1'b1; challenge = 3'd3; end
            if (lat == 6) begin start = 1'b0; end
            if (done) begin
                dones++;
                lat_done = lat;
                resp_seen = int'(response);
            end
        end
        check("R3", "done count with ignored start", dones, 1);
        check("R3", "completion edge unchanged", lat_done, 257);
        check("R3", "response of first challenge kept", resp_seen, 1);
        check("R3", "idle after run", int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule